// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries of a forward page table held in memory. A request carries the virtual address and whether the access is a store. The walker reads a first-level entry, located from a root page register. That entry names the page that holds the second-level table. It then reads the leaf entry and checks the leaf's valid and permission flags against the access type. A good walk returns the leaf's physical page number joined to the offset, which passes through untouched. A bad walk returns an error that says which level stopped the walk and why.

The address splits into a 10-bit top index (bits 31:22), a 10-bit middle index (bits 21:12) and a 12-bit offset (bits 11:0). Tables are one 4 KB page each and hold 1024 four-byte entries. Memory is reached through a plain read port: a one-cycle request pulse with a word address, then a data word qualified by a valid strobe. The walker handles one translation at a time. On an address-space switch, kernel code rewrites the root register, and nothing else needs to change.

Top module: `xlate_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `resp_done` and `mem_rd_req` are 0.
- R2: The first read of a walk goes to byte address {root_ppn, vaddr[31:22], 2'b00}.
- R3: The second read goes to byte address {l1_entry[31:12], vaddr[21:12], 2'b00}.
- R4: A walk that succeeds reports `resp_err`=0 and `resp_paddr` = {leaf[31:12], vaddr[11:0]}.
- R5: If bit 0 (valid) of the first-level entry is 0, the walk ends after that single read. The response has `resp_err`=1, `resp_err_level`=0, `resp_err_cause`=0 and `resp_paddr`=0.
- R6: If bit 0 of the leaf entry is 0, the response has `resp_err`=1, `resp_err_level`=1, `resp_err_cause`=0 and `resp_paddr`=0.
- R7: A valid leaf permits a load only if bit 1 (read) is set, and a store only if bit 2 (write) is set. A denied access responds with `resp_err`=1, `resp_err_level`=1, `resp_err_cause`=1 and `resp_paddr`=0.
- R8: A complete walk makes exactly two reads, each request lasting one cycle.
- R9: Each accepted request produces exactly one `resp_done` pulse of one cycle. `req_ready` is high only while the walker is idle, and a request presented while it is busy is ignored.
- R10: The root register takes `root_wr_data` only when `root_wr_en` and `priv_kernel` are both 1. A write attempted with `priv_kernel`=0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| root_wr_en | input | 1 | Root page register write strobe |
| root_wr_data | input | 20 | Page number of the first-level table |
| priv_kernel | input | 1 | Writer is in kernel mode |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store access, 0 = load access |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_rd_req | output | 1 | Memory read request pulse |
| mem_rd_addr | output | 32 | Byte address of the entry word |
| mem_rd_data | input | 32 | Entry word returned |
| mem_rd_valid | input | 1 | `mem_rd_data` is valid |
| resp_done | output | 1 | One-cycle completion strobe |
| resp_paddr | output | 32 | Physical address (0 on error) |
| resp_err | output | 1 | Access error |
| resp_err_level | output | 1 | 0 = first level, 1 = leaf |
| resp_err_cause | output | 1 | 0 = invalid entry, 1 = permission denied |

## Verification
The bench aims at three kinds of leaf: valid but not readable, valid but not writable, and permission flags set without the valid bit. Swapping the read and write flags, or ignoring the valid bit, would each return a physical address where an error is expected. An invalid first-level entry must stop the walk after one read. A walker that carries on would issue a second read to a stray address and report the wrong level. Offsets of all-zeros and all-ones catch bits of the offset that are dropped or replaced by table bits. Other cases are a user-mode write to the root register, which would silently redirect later walks, and a request held high while the walker is busy, which would start a second walk or alter the address of the first.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  parameter int VA_W   = 32;
  parameter int IDX_W  = 10;
  parameter int OFF_W  = 12;
  localparam int PPN_W  = VA_W - OFF_W;
  localparam int EBYTE_LOG2 = OFF_W - IDX_W;

  localparam int FLAG_V = 0;
  localparam int FLAG_R = 1;
  localparam int FLAG_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_L1, ST_WAIT_L1, ST_FETCH_L2, ST_WAIT_L2, ST_DONE, ST_ERROR
  } walk_state_t;

  // byte address of an entry in a page-aligned table
  function automatic logic [VA_W-1:0] entry_addr(input logic [PPN_W-1:0] tbl_ppn,
                                                 input logic [IDX_W-1:0] idx);
    return {tbl_ppn, idx, {EBYTE_LOG2{1'b0}}};
  endfunction
endpackage

// File: rtl/xlate_addr_gen.sv
module xlate_addr_gen
  import xlate_pkg::*;
(
  input  logic             use_leaf,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [PPN_W-1:0] next_ppn,
  input  logic [VA_W-1:0]  vaddr,
  output logic [VA_W-1:0]  addr
);
  localparam int HI_IDX_LSB = OFF_W + IDX_W;

  logic [IDX_W-1:0] idx_top;
  logic [IDX_W-1:0] idx_mid;
  logic             unused_off;

  assign idx_top    = vaddr[VA_W-1:HI_IDX_LSB];
  assign idx_mid    = vaddr[HI_IDX_LSB-1:OFF_W];
  assign unused_off = ^vaddr[OFF_W-1:0];
  assign addr       = use_leaf ? entry_addr(next_ppn, idx_mid) : entry_addr(root_ppn, idx_top);
endmodule

// File: rtl/xlate_entry_check.sv
module xlate_entry_check
  import xlate_pkg::*;
(
  input  logic [2:0] flags,
  input  logic       is_leaf,
  input  logic       want_write,
  output logic       ok,
  output logic       cause_perm
);
  logic perm_ok;

  assign perm_ok = want_write ? flags[FLAG_W] : flags[FLAG_R];

  always_comb begin
    if (!flags[FLAG_V]) begin
      ok         = 1'b0;
      cause_perm = 1'b0;
    end else if (is_leaf) begin
      ok         = perm_ok;
      cause_perm = !perm_ok;
    end else begin
      ok         = 1'b1;
      cause_perm = 1'b0;
    end
  end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             root_wr_en,
  input  logic [19:0]      root_wr_data,
  input  logic             priv_kernel,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic             req_write,
  output logic             req_ready,
  output logic             mem_rd_req,
  output logic [31:0]      mem_rd_addr,
  input  logic [31:0]      mem_rd_data,
  input  logic             mem_rd_valid,
  output logic             resp_done,
  output logic [31:0]      resp_paddr,
  output logic             resp_err,
  output logic             resp_err_level,
  output logic             resp_err_cause
);
  walk_state_t      state_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PPN_W-1:0] root_q;
  logic [PPN_W-1:0] next_ppn_q;
  logic [VA_W-1:0]  paddr_q;
  logic             lvl_q;
  logic             cause_q;

  // named internal events
  logic in_l1_fetch;
  logic in_leaf_phase;
  logic entry_ok;
  logic entry_perm;
  logic root_write_ok;
  logic accept;
  logic unused_mid_bits;

  assign in_l1_fetch   = (state_q == ST_FETCH_L1);
  assign in_leaf_phase = (state_q == ST_FETCH_L2) || (state_q == ST_WAIT_L2);
  assign root_write_ok = root_wr_en && priv_kernel;
  assign accept        = (state_q == ST_IDLE) && req_valid;
  assign unused_mid_bits = ^mem_rd_data[OFF_W-1:3];

  xlate_addr_gen u_addr (
    .use_leaf (in_leaf_phase),
    .root_ppn (root_q),
    .next_ppn (next_ppn_q),
    .vaddr    (va_q),
    .addr     (mem_rd_addr)
  );

  xlate_entry_check u_chk_entry (
    .flags      (mem_rd_data[2:0]),
    .is_leaf    (state_q == ST_WAIT_L2),
    .want_write (wr_q),
    .ok         (entry_ok),
    .cause_perm (entry_perm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_q <= '0;
    end else if (root_write_ok) begin
      root_q <= root_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      next_ppn_q <= '0;
      paddr_q    <= '0;
      lvl_q      <= 1'b0;
      cause_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            va_q    <= req_vaddr;
            wr_q    <= req_write;
            paddr_q <= '0;
            lvl_q   <= 1'b0;
            cause_q <= 1'b0;
            state_q <= ST_FETCH_L1;
          end
        end
        ST_FETCH_L1: state_q <= ST_WAIT_L1;
        ST_WAIT_L1: begin
          if (mem_rd_valid) begin
            if (entry_ok) begin
              next_ppn_q <= mem_rd_data[VA_W-1:OFF_W];
              state_q    <= ST_FETCH_L2;
            end else begin
              lvl_q   <= 1'b0;
              cause_q <= entry_perm;
              state_q <= ST_ERROR;
            end
          end
        end
        ST_FETCH_L2: state_q <= ST_WAIT_L2;
        ST_WAIT_L2: begin
          if (mem_rd_valid) begin
            if (entry_ok) begin
              paddr_q <= {mem_rd_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
              state_q <= ST_DONE;
            end else begin
              lvl_q   <= 1'b1;
              cause_q <= entry_perm;
              state_q <= ST_ERROR;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign mem_rd_req     = in_l1_fetch || (state_q == ST_FETCH_L2);
  assign resp_done      = (state_q == ST_DONE) || (state_q == ST_ERROR);
  assign resp_err       = (state_q == ST_ERROR);
  assign resp_paddr     = paddr_q;
  assign resp_err_level = lvl_q;
  assign resp_err_cause = cause_q;
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        root_wr_en,
  input logic        priv_kernel,
  input logic        req_ready,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        resp_done,
  input logic        resp_err,
  input logic [31:0] resp_paddr,
  input logic        in_l1_fetch,
  input logic [31:0] va_q,
  input logic [19:0] root_q
);
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> (!resp_done && req_ready));

  assert_no_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_req);

  assert_l1_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && in_l1_fetch) |-> (mem_rd_addr == {root_q, va_q[31:22], 2'b00}));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && !resp_err) |-> (resp_paddr[11:0] == va_q[11:0]));

  assert_err_zero_paddr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_err) |-> (resp_paddr == 32'd0));

  assert_user_root_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (root_wr_en && !priv_kernel) |=> $stable(root_q));
endmodule

bind xlate_walker xlate_walker_chk u_walker_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .root_wr_en  (root_wr_en),
  .priv_kernel (priv_kernel),
  .req_ready   (req_ready),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .resp_done   (resp_done),
  .resp_err    (resp_err),
  .resp_paddr  (resp_paddr),
  .in_l1_fetch (in_l1_fetch),
  .va_q        (va_q),
  .root_q      (root_q)
);

// File: tb/xlate_walker_bench.sv
module xlate_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_wr_en = 1'b0;
  logic [19:0] root_wr_data = '0;
  logic        priv_kernel = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        mem_rd_valid = 1'b0;
  logic        resp_done;
  logic [31:0] resp_paddr;
  logic        resp_err;
  logic        resp_err_level;
  logic        resp_err_cause;

  always #2.5 clk = ~clk;

  xlate_walker u_xlate_walker (.*);

  typedef struct {
    logic [31:0] paddr;
    logic        err;
    logic        lvl;
    logic        cause;
    int          nreads;
    logic [31:0] a1;
    logic [31:0] a2;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mem_img [logic [31:0]];
  logic [19:0] model_root = '0;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          n_resp = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_seen [4];
  bit          ended = 0;

  function automatic logic [31:0] mem_get(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'd0;
  endfunction

  // memory responder: one cycle after a request, data with valid
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_req) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= mem_get(mem_rd_addr);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // reference walk, written from the requirements
  function automatic exp_t model(input logic [31:0] va, input logic wr, input string tag);
    exp_t e;
    logic [31:0] l1, l2;
    logic perm;
    e.tag = tag; e.err = 0; e.lvl = 0; e.cause = 0; e.paddr = 0; e.a2 = 0;
    e.a1 = (32'(model_root) << 12) + 32'(va[31:22]) * 4;
    l1 = mem_get(e.a1);
    e.nreads = 1;
    if (!l1[0]) begin e.err = 1; return e; end
    e.nreads = 2;
    e.a2 = (32'(l1[31:12]) << 12) + 32'(va[21:12]) * 4;
    l2 = mem_get(e.a2);
    perm = wr ? l2[2] : l2[1];
    if (!l2[0]) begin e.err = 1; e.lvl = 1; return e; end
    if (!perm) begin e.err = 1; e.lvl = 1; e.cause = 1; return e; end
    e.paddr = {l2[31:12], va[11:0]};
    return e;
  endfunction

  task automatic issue(input logic [31:0] va, input logic wr, input string tag, input bit noise);
    while (!req_ready) @(negedge clk);
    sb_q.push_back(model(va, wr, tag));
    req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    if (noise) begin
      req_vaddr = ~va; req_write = ~wr;
      repeat (3) @(negedge clk);
    end
    req_valid = 0;
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_root(input logic [19:0] ppn, input logic kern);
    @(negedge clk);
    root_wr_en = 1; root_wr_data = ppn; priv_kernel = kern;
    if (kern) model_root = ppn;
    @(negedge clk);
    root_wr_en = 0; priv_kernel = 0;
  endtask

  // monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_rd_req && rd_cnt < 4) begin
      rd_seen[rd_cnt] = mem_rd_addr;
      rd_cnt++;
    end else if (rst_n && mem_rd_req) begin
      rd_cnt++;
    end
    if (rst_n && resp_done) begin
      n_resp++;
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 unexpected response actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " R4 paddr"}, resp_paddr, e.paddr);
        chk({e.tag, " R5/R6/R7 err"}, {31'd0, resp_err}, {31'd0, e.err});
        if (e.err) begin
          chk({e.tag, " R5/R6 level"}, {31'd0, resp_err_level}, {31'd0, e.lvl});
          chk({e.tag, " R7 cause"}, {31'd0, resp_err_cause}, {31'd0, e.cause});
        end
        chk({e.tag, " R8 read count"}, rd_cnt, e.nreads);
        chk({e.tag, " R2 first addr"}, rd_seen[0], e.a1);
        if (e.nreads == 2) chk({e.tag, " R3 second addr"}, rd_seen[1], e.a2);
      end
      rd_cnt = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    // page tables: root page 0x00040, leaf table page 0x00050
    mem_img[32'h0004_0004] = {20'h00050, 12'h001};
    mem_img[32'h0005_0008] = {20'hABCDE, 12'h003}; // V R
    mem_img[32'h0005_000C] = {20'h12345, 12'h007}; // V R W
    mem_img[32'h0005_0010] = {20'h55555, 12'h006}; // R W, not valid
    mem_img[32'h0005_0014] = {20'h77777, 12'h005}; // V W
    mem_img[32'h0004_001C] = {20'h00099, 12'h006}; // first level invalid
    // second address space: root 0x00060, leaf table 0x00070
    mem_img[32'h0006_0004] = {20'h00070, 12'h001};
    mem_img[32'h0007_0008] = {20'h22222, 12'h003};

    repeat (3) @(negedge clk);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 resp_done", {31'd0, resp_done}, 32'd0);
    chk("R1 mem_rd_req", {31'd0, mem_rd_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    set_root(20'h00040, 1);
    issue({10'd1, 10'd2, 12'h345}, 0, "R4 load ok", 0);
    issue({10'd1, 10'd2, 12'h000}, 1, "R7 store no W", 0);
    issue({10'd1, 10'd3, 12'hFFF}, 1, "R7 store ok", 0);
    issue({10'd1, 10'd3, 12'h000}, 0, "R4 load off0", 0);
    issue({10'd1, 10'd4, 12'h123}, 0, "R6 leaf invalid", 0);
    issue({10'd1, 10'd5, 12'h456}, 0, "R7 load no R", 0);
    issue({10'd1, 10'd5, 12'hFFF}, 1, "R7 store W only", 0);
    issue({10'd7, 10'd2, 12'h789}, 0, "R5 l1 invalid", 0);
    issue({10'd9, 10'd9, 12'h001}, 1, "R5 l1 absent", 0);

    set_root(20'h00060, 0);
    issue({10'd1, 10'd2, 12'hABC}, 0, "R10 user root ignored", 0);
    set_root(20'h00060, 1);
    issue({10'd1, 10'd2, 12'hABC}, 0, "R10 kernel root", 0);

    set_root(20'h00040, 1);
    issue({10'd1, 10'd3, 12'h0F0}, 0, "R9 busy request", 1);
    repeat (8) @(negedge clk);
    chk("R9 response count", n_resp, 12);
    chk("R9 idle after", {31'd0, req_ready}, 32'd1);
    report();
  end
endmodule